// File: doc/BRIEF.md
# Linked-Descriptor Frame Fetcher

This block pulls display data out of memory for a panel controller. Each channel follows a chain of descriptors held in memory. A descriptor names a source buffer, gives a length in 32-bit words, and says whether that buffer holds colour-table entries or pixels. The block reads the buffer in bursts and places the words in a per-channel output FIFO. Each word carries a tag that tells the downstream stage whether it is a colour-table entry or a pixel. When a transfer is finished, the block follows the descriptor's next pointer. A chain normally loops forever. In indexed-colour modes, a colour-table descriptor and a frame descriptor point at each other. In true-colour modes, a single frame descriptor points at itself.

Channel 0 always serves the display. Channel 1 has its own start pointer and serves the lower half of a two-panel display. It runs only when two-panel operation is selected. Both channels share one burst read port, and only one burst is outstanding at a time.

The pixel side pulls one word per slot. An optional underrun guard handles the case where that side pulls from an empty FIFO. With the guard on, the output repeats the last word delivered and a sticky flag is raised.

Top module: `frame_desc_dma`

## Requirements
- R1: When a channel is enabled, it reads the descriptor at its start pointer as a single burst of length 4. The words arrive in this order: next-descriptor address, source address, frame tag (ignored), command word.
- R2: Command bits [23:0] give the transfer length in 32-bit words. Exactly that many words, read from consecutive addresses starting at the source address, reach the output. A length of 0 delivers nothing and the chain moves on to the next descriptor.
- R3: When command bit 28 is 1, every word of that transfer leaves with px_pal=1. When it is 0, every word leaves with px_pal=0.
- R4: Buffer data is requested in bursts of 16 words, with one shorter final burst for any remainder. A burst is requested only when the channel's FIFO has room for all of it.
- R5: The next descriptor is requested only after the consumer has taken the last word of the current transfer, so the channel's FIFO is empty.
- R6: A chain follows its next pointers without end. A descriptor that points at itself repeats its buffer, and two descriptors that point at each other alternate.
- R7: Channel 0 starts at start_addr[31:0]. Channel 1 starts at start_addr[63:32] and runs only while dual_en=1. Otherwise channel 1 issues no requests and produces no output.
- R8: Suppose urun_protect=1, at least one word has been delivered since the channel started, and px_take is high while the channel's FIFO is empty. Then px_valid stays 1, px_data and px_pal repeat the last delivered word, and urun_flag sets. The flag stays set until the channel next restarts its chain.
- R9: With urun_protect=0, an empty FIFO gives px_valid=0, px_take has no effect, and urun_flag stays 0.
- R10: When fetch_en falls, a burst already granted completes and no further request is issued. When fetch_en rises again, each channel restarts from the descriptor at its start pointer.
- R11: Only one burst is outstanding on the memory port. Its response words go only to the channel that owns it, and the channels take turns in round-robin order.
- R12: After reset there is no memory request, px_valid is 0 and urun_flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_en | input | 1 | Run the chains |
| dual_en | input | 1 | Two-panel operation; enables channel 1 |
| urun_protect | input | 1 | Repeat the last word on an empty FIFO |
| start_addr | input | 64 | First-descriptor pointers, channel n in bits [32n+31:32n] |
| mem_req_valid | output | 1 | Burst read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the first word |
| mem_req_len | output | 5 | Burst length in words (1 to 16) |
| mem_rsp_valid | input | 1 | Read data word present |
| mem_rsp_data | input | 32 | Read data word |
| mem_rsp_last | input | 1 | Final word of the burst |
| px_take | input | 2 | Per channel: consumer takes the word shown this cycle |
| px_valid | output | 2 | Per channel: a word is shown |
| px_data | output | 64 | Per channel: data word, channel n in bits [32n+31:32n] |
| px_pal | output | 2 | Per channel: 1 for a colour-table word, 0 for a pixel word |
| urun_flag | output | 2 | Per channel: sticky underrun indicator |

## Verification
The bench starts with the consumer stalled and checks that no third request appears while colour-table words are still waiting. A fetcher that prefetched the next descriptor would show that extra request. It runs a 20-word frame, which catches a fetcher that rounds the length up to a full burst, splits it in the wrong place, or loses the tag across a chain step. A zero-length colour-table descriptor placed in front of a self-looping frame catches a design that hangs or emits stray tagged words. The bench also drops fetch_en in the middle of a frame and expects whole bursts only, then a restart from the start pointer rather than from where the chain stopped. It starves the consumer with the guard on and checks that every repeated word equals its predecessor and that the flag is raised and later cleared.

// File: rtl/fdma_pkg.sv
// Shared constants and state type for the descriptor-chain fetcher.
package fdma_pkg;
    localparam int PAL_FLAG_BIT = 28;   // command bit: transfer holds colour-table data
    localparam int DESC_WORDS   = 4;    // words per descriptor

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_RX,
        ST_XFER_REQ,
        ST_XFER_RX,
        ST_DRAIN
    } eng_state_t;
endpackage

// File: rtl/fdma_out_fifo.sv
// Per-channel output FIFO with an optional underrun guard.
// What it does: stores tagged words from the engine and shows the head word
// to the pixel side. When the guard is on and the FIFO is empty, it shows
// the last word taken again and sets a sticky flag on each take.
// Assumes: DEPTH is a power of two, and the engine never pushes without room.
module fdma_out_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             push_pal,
    input  logic             restart,
    input  logic             protect,
    input  logic             take,
    output logic             px_valid,
    output logic [DW-1:0]    px_data,
    output logic             px_pal,
    output logic             urun,
    output logic [CNT_W-1:0] free,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW:0]        store [DEPTH];
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   count;
    logic [DW:0]        last_q;
    logic               have_last;
    logic [DW:0]        head;
    logic               pop;

    // Head word and pop condition.
    always_comb begin
        head  = store[rd_ptr];
        empty = (count == '0);
        pop   = take && !empty;
        free  = CNT_W'(DEPTH) - count;
    end

    // Output select: head word, or the repeated last word when starved.
    always_comb begin
        px_valid = !empty || (protect && have_last);
        px_data  = empty ? last_q[DW-1:0] : head[DW-1:0];
        px_pal   = empty ? last_q[DW]     : head[DW];
    end

    // Data storage write port.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= {push_pal, push_data};
    end

    // Pointers, occupancy, last-word register and sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            last_q    <= '0;
            have_last <= 1'b0;
            urun      <= 1'b0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop) begin
                rd_ptr    <= rd_ptr + 1'b1;
                last_q    <= head;
                have_last <= 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (restart) begin
                have_last <= 1'b0;
                urun      <= 1'b0;
            end else if (take && empty && protect && have_last) begin
                urun <= 1'b1;
            end
        end
    end

    // R4: the engine's room check must keep pushes within capacity.
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH)));

    // R8: the underrun flag holds until a restart.
    assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (urun && !restart) |=> urun);
endmodule

// File: rtl/fdma_chan_engine.sv
// One descriptor-chain engine.
// What it does: fetches a 4-word descriptor, streams the buffer it names in
// bursts into the channel FIFO, waits for the FIFO to drain, then follows
// the next pointer. A low enable stops it at the next burst boundary.
// Assumes: memory returns exactly the requested number of words in order,
// with the last one flagged.
module fdma_chan_engine
    import fdma_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int BURST  = 16,
    parameter int LEN_W  = 24,
    parameter int BLEN_W = 5,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ch_en,
    input  logic [AW-1:0]     start_addr,
    output logic              req_valid,
    output logic [AW-1:0]     req_addr,
    output logic [BLEN_W-1:0] req_len,
    input  logic              req_gnt,
    input  logic              rsp_valid,
    input  logic [DW-1:0]     rsp_data,
    input  logic              rsp_last,
    input  logic [CNT_W-1:0]  fifo_free,
    input  logic              fifo_empty,
    output logic              push,
    output logic [DW-1:0]     push_data,
    output logic              push_pal,
    output logic              restart
);
    eng_state_t        state;
    logic [AW-1:0]     desc_ptr, next_ptr, src_ptr;
    logic [LEN_W-1:0]  remain;
    logic              pal_q;
    logic [1:0]        wcnt;
    logic [BLEN_W-1:0] burst_len;

    // Size of the next data burst: a full burst or the remainder.
    always_comb begin
        if (remain >= LEN_W'(BURST)) burst_len = BLEN_W'(BURST);
        else                         burst_len = remain[BLEN_W-1:0];
    end

    // Request generation for descriptor and data bursts.
    always_comb begin
        req_valid = 1'b0;
        req_addr  = desc_ptr;
        req_len   = BLEN_W'(DESC_WORDS);
        case (state)
            ST_DESC_REQ: req_valid = ch_en;
            ST_XFER_REQ: begin
                req_valid = ch_en && (remain != '0) && (fifo_free >= CNT_W'(burst_len));
                req_addr  = src_ptr;
                req_len   = burst_len;
            end
            default: ;
        endcase
    end

    // FIFO push of buffer words, tagged with the transfer's kind.
    always_comb begin
        push      = (state == ST_XFER_RX) && rsp_valid;
        push_data = rsp_data;
        push_pal  = pal_q;
        restart   = (state == ST_IDLE) && ch_en;
    end

    // Chain walker state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            desc_ptr <= '0;
            next_ptr <= '0;
            src_ptr  <= '0;
            remain   <= '0;
            pal_q    <= 1'b0;
            wcnt     <= '0;
        end else begin
            case (state)
                ST_IDLE: if (ch_en) begin
                    desc_ptr <= start_addr;
                    state    <= ST_DESC_REQ;
                end
                ST_DESC_REQ: begin
                    if (!ch_en) state <= ST_IDLE;
                    else if (req_gnt) begin
                        wcnt  <= '0;
                        state <= ST_DESC_RX;
                    end
                end
                ST_DESC_RX: if (rsp_valid) begin
                    case (wcnt)
                        2'd0: next_ptr <= rsp_data[AW-1:0];
                        2'd1: src_ptr  <= rsp_data[AW-1:0];
                        2'd3: begin
                            remain <= rsp_data[LEN_W-1:0];
                            pal_q  <= rsp_data[PAL_FLAG_BIT];
                        end
                        default: ;
                    endcase
                    wcnt <= wcnt + 1'b1;
                    if (rsp_last) state <= ST_XFER_REQ;
                end
                ST_XFER_REQ: begin
                    if (!ch_en)              state <= ST_IDLE;
                    else if (remain == '0)   state <= ST_DRAIN;
                    else if (req_gnt)        state <= ST_XFER_RX;
                end
                ST_XFER_RX: if (rsp_valid && rsp_last) begin
                    src_ptr <= src_ptr + (AW'(burst_len) << 2);
                    remain  <= remain - LEN_W'(burst_len);
                    state   <= ST_XFER_REQ;
                end
                ST_DRAIN: begin
                    if (!ch_en) state <= ST_IDLE;
                    else if (fifo_empty) begin
                        desc_ptr <= next_ptr;
                        state    <= ST_DESC_REQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: no word is delivered beyond the transfer length.
    assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (remain != '0));

    // R4: a granted data burst always fits in the FIFO.
    assert_room_on_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_gnt && state == ST_XFER_REQ) |-> (fifo_free >= CNT_W'(req_len)));

    // R5: moving to the next descriptor requires an empty FIFO.
    assert_desc_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DESC_REQ && $past(state) == ST_DRAIN) |-> $past(fifo_empty));

    // R10: with enable low, outside a burst, the engine parks.
    assert_stop_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_en && state != ST_DESC_RX && state != ST_XFER_RX) |=> (state == ST_IDLE));
endmodule

// File: rtl/fdma_mem_arb.sv
// Round-robin arbiter for the shared burst read port.
// What it does: grants one channel's request, holds ownership until the
// flagged last response word, and routes response words to the owner.
// Assumes: the memory answers each accepted request with a burst ending in last.
module fdma_mem_arb #(
    parameter int NUM_CH = 2,
    parameter int AW     = 32,
    parameter int BLEN_W = 5,
    parameter int OW     = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        ch_req_valid,
    input  logic [NUM_CH*AW-1:0]     ch_req_addr,
    input  logic [NUM_CH*BLEN_W-1:0] ch_req_len,
    output logic [NUM_CH-1:0]        ch_gnt,
    output logic [NUM_CH-1:0]        ch_rsp_valid,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [AW-1:0]            mem_req_addr,
    output logic [BLEN_W-1:0]        mem_req_len,
    input  logic                     mem_rsp_valid,
    input  logic                     mem_rsp_last
);
    logic          busy;
    logic [OW-1:0] owner, rr_last, sel;
    logic          any;

    // Pick the first requester after the last winner.
    always_comb begin
        int cand;
        sel = rr_last;
        any = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            cand = (int'(rr_last) + 1 + i) % NUM_CH;
            if (!any && ch_req_valid[cand]) begin
                any = 1'b1;
                sel = OW'(cand);
            end
        end
    end

    // Drive the memory request and the grant pulse.
    always_comb begin
        mem_req_valid = !busy && any;
        mem_req_addr  = ch_req_addr[sel*AW +: AW];
        mem_req_len   = ch_req_len[sel*BLEN_W +: BLEN_W];
        ch_gnt        = '0;
        if (mem_req_valid && mem_req_ready) ch_gnt[sel] = 1'b1;
    end

    // Response routing to the burst owner.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_route
        assign ch_rsp_valid[g] = mem_rsp_valid && busy && (owner == OW'(g));
    end

    // Ownership and round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            owner   <= '0;
            rr_last <= OW'(NUM_CH - 1);
        end else if (!busy) begin
            if (mem_req_valid && mem_req_ready) begin
                busy    <= 1'b1;
                owner   <= sel;
                rr_last <= sel;
            end
        end else if (mem_rsp_valid && mem_rsp_last) begin
            busy <= 1'b0;
        end
    end

    // R11: at most one channel granted per cycle.
    assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_gnt));

    // R11: ownership holds until the burst's last word.
    assert_owner_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(mem_rsp_valid && mem_rsp_last)) |=> (busy && $stable(owner)));
endmodule

// File: rtl/frame_desc_dma.sv
// Top of the linked-descriptor frame fetcher.
// What it does: instantiates one chain engine and one output FIFO per
// channel and shares the burst read port through a round-robin arbiter.
// Channels above 0 run only in two-panel operation.
// Assumes: start pointers are stable while fetch_en is high.
module frame_desc_dma #(
    parameter int NUM_CH     = 2,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int BURST      = 16,
    parameter int LEN_W      = 24,
    parameter int FIFO_DEPTH = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_en,
    input  logic                 dual_en,
    input  logic                 urun_protect,
    input  logic [NUM_CH*AW-1:0] start_addr,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [AW-1:0]        mem_req_addr,
    output logic [$clog2(BURST+1)-1:0] mem_req_len,
    input  logic                 mem_rsp_valid,
    input  logic [DW-1:0]        mem_rsp_data,
    input  logic                 mem_rsp_last,
    input  logic [NUM_CH-1:0]    px_take,
    output logic [NUM_CH-1:0]    px_valid,
    output logic [NUM_CH*DW-1:0] px_data,
    output logic [NUM_CH-1:0]    px_pal,
    output logic [NUM_CH-1:0]    urun_flag
);
    localparam int BLEN_W = $clog2(BURST + 1);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int OW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [NUM_CH-1:0]        ch_en, ch_req_valid, ch_gnt, ch_rsp_valid;
    logic [NUM_CH*AW-1:0]     ch_req_addr;
    logic [NUM_CH*BLEN_W-1:0] ch_req_len;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic             push, push_pal, restart, fifo_empty;
        logic [DW-1:0]    push_data;
        logic [CNT_W-1:0] fifo_free;

        // Channel 0 always runs; the rest only in two-panel operation.
        assign ch_en[c] = fetch_en && ((c == 0) || dual_en);

        fdma_chan_engine #(
            .AW(AW), .DW(DW), .BURST(BURST), .LEN_W(LEN_W),
            .BLEN_W(BLEN_W), .CNT_W(CNT_W)
        ) eng_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .ch_en      (ch_en[c]),
            .start_addr (start_addr[c*AW +: AW]),
            .req_valid  (ch_req_valid[c]),
            .req_addr   (ch_req_addr[c*AW +: AW]),
            .req_len    (ch_req_len[c*BLEN_W +: BLEN_W]),
            .req_gnt    (ch_gnt[c]),
            .rsp_valid  (ch_rsp_valid[c]),
            .rsp_data   (mem_rsp_data),
            .rsp_last   (mem_rsp_last),
            .fifo_free  (fifo_free),
            .fifo_empty (fifo_empty),
            .push       (push),
            .push_data  (push_data),
            .push_pal   (push_pal),
            .restart    (restart)
        );

        fdma_out_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) fifo_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push),
            .push_data (push_data),
            .push_pal  (push_pal),
            .restart   (restart),
            .protect   (urun_protect),
            .take      (px_take[c]),
            .px_valid  (px_valid[c]),
            .px_data   (px_data[c*DW +: DW]),
            .px_pal    (px_pal[c]),
            .urun      (urun_flag[c]),
            .free      (fifo_free),
            .empty     (fifo_empty)
        );
    end

    fdma_mem_arb #(.NUM_CH(NUM_CH), .AW(AW), .BLEN_W(BLEN_W), .OW(OW)) arb_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .ch_req_valid  (ch_req_valid),
        .ch_req_addr   (ch_req_addr),
        .ch_req_len    (ch_req_len),
        .ch_gnt        (ch_gnt),
        .ch_rsp_valid  (ch_rsp_valid),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_len   (mem_req_len),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_last  (mem_rsp_last)
    );
endmodule

// File: tb/frame_desc_dma_tb.sv
module frame_desc_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_en = 1'b0, dual_en = 1'b0, urun_protect = 1'b0;
    logic [63:0] start_addr = '0;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic [4:0]  mem_req_len;
    logic        mem_rsp_valid, mem_rsp_last;
    logic [31:0] mem_rsp_data;
    logic [1:0]  px_take = 2'b00;
    logic [1:0]  px_valid, px_pal, urun_flag;
    logic [63:0] px_data;

    int checks = 0, failures = 0, cycles = 0;

    frame_desc_dma dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .dual_en(dual_en),
        .urun_protect(urun_protect), .start_addr(start_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_rsp_last(mem_rsp_last), .px_take(px_take), .px_valid(px_valid),
        .px_data(px_data), .px_pal(px_pal), .urun_flag(urun_flag)
    );

    always #5 clk = ~clk;

    // Memory model: one burst at a time, one word per cycle after acceptance.
    logic [31:0] bmem [1024];
    logic        mm_busy;
    logic [31:0] mm_addr;
    logic [4:0]  mm_left;
    logic [31:0] req_addr_log [512];
    int          req_len_log [512];
    int          req_n = 0;
    assign mem_req_ready = !mm_busy;

    always @(posedge clk) begin
        if (!rst_n) begin
            mm_busy <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_last <= 1'b0;
            mem_rsp_data <= '0; mm_addr <= '0; mm_left <= '0;
        end else begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_last  <= 1'b0;
            if (mm_busy) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= bmem[mm_addr[11:2]];
                mem_rsp_last  <= (mm_left == 5'd1);
                mm_addr <= mm_addr + 32'd4;
                mm_left <= mm_left - 5'd1;
                if (mm_left == 5'd1) mm_busy <= 1'b0;
            end else if (mem_req_valid) begin
                mm_busy <= 1'b1;
                mm_addr <= mem_req_addr;
                mm_left <= mem_req_len;
                if (req_n < 512) begin
                    req_addr_log[req_n] = mem_req_addr;
                    req_len_log[req_n]  = int'(mem_req_len);
                end
                req_n++;
            end
        end
    end

    // Capture of words handed to the consumer, sampled mid-cycle.
    logic [31:0] cap_d [2][512];
    logic        cap_p [2][512];
    int          cap_n [2];
    always @(negedge clk) begin
        cycles++;
        for (int c = 0; c < 2; c++) begin
            if (rst_n && px_take[c] && px_valid[c]) begin
                if (cap_n[c] < 512) begin
                    cap_d[c][cap_n[c]] = px_data[c*32 +: 32];
                    cap_p[c][cap_n[c]] = px_pal[c];
                end
                cap_n[c]++;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return 32'h5A00_0000 | (a >> 2);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        req_n = 0; cap_n[0] = 0; cap_n[1] = 0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] src, input logic [31:0] cmd);
        bmem[a[11:2]]     = nxt;
        bmem[a[11:2] + 1] = src;
        bmem[a[11:2] + 2] = 32'h0;
        bmem[a[11:2] + 3] = cmd;
    endtask

    task automatic do_reset();
        fetch_en = 0; px_take = 0; dual_en = 0; urun_protect = 0;
        for (int i = 0; i < 1024; i++) bmem[i] = 32'h5A00_0000 | i;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        clear_logs();
    endtask

    task automatic wait_caps(input int n0, input int n1, input int limit);
        for (int i = 0; i < limit; i++) begin
            if (cap_n[0] >= n0 && cap_n[1] >= n1) break;
            @(negedge clk);
        end
    endtask

    // R12: idle outputs after reset.
    task automatic t_reset();
        do_reset();
        repeat (4) @(negedge clk);
        check(mem_req_valid == 0, "R12 no request", 32'(mem_req_valid), 0);
        check(px_valid == 2'b00, "R12 px_valid", 32'(px_valid), 0);
        check(urun_flag == 2'b00, "R12 urun_flag", 32'(urun_flag), 0);
    endtask

    // R1 R2 R3 R4 R6 R7 R9: colour table / frame loop on channel 0.
    task automatic t_pal_loop();
        int bad = 0;
        logic [31:0] exp_a [6] = '{32'h000, 32'h400, 32'h040, 32'h600, 32'h640, 32'h000};
        int          exp_l [6] = '{4, 4, 4, 16, 4, 4};
        do_reset();
        put_desc(32'h000, 32'h040, 32'h400, 32'h1000_0004);
        put_desc(32'h040, 32'h000, 32'h600, 32'd20);
        start_addr = {32'h0E0, 32'h000};
        px_take = 2'b01; fetch_en = 1;
        wait_caps(48, 0, 3000);
        for (int k = 0; k < 48; k++) begin
            int p = k % 24;
            logic [31:0] e = (p < 4) ? word_at(32'h400 + 32'(p*4)) : word_at(32'h600 + 32'((p-4)*4));
            if (cap_d[0][k] !== e || cap_p[0][k] !== (p < 4)) bad++;
        end
        check(cap_n[0] >= 48, "R6 chain keeps looping", 32'(cap_n[0]), 48);
        check(bad == 0, "R2 R3 word order and tag", 32'(bad), 0);
        for (int i = 0; i < 6; i++) begin
            check(req_addr_log[i] == exp_a[i] && req_len_log[i] == exp_l[i],
                  (i == 0) ? "R1 descriptor burst" : "R4 burst split",
                  req_addr_log[i], exp_a[i]);
        end
        check(cap_n[1] == 0, "R7 channel 1 idle", 32'(cap_n[1]), 0);
        check(urun_flag == 2'b00, "R9 no flag unguarded", 32'(urun_flag), 0);
        fetch_en = 0;
        repeat (200) @(negedge clk);
    endtask

    // R5: stalled consumer blocks the next descriptor fetch.
    task automatic t_drain_gate();
        do_reset();
        put_desc(32'h000, 32'h040, 32'h400, 32'h1000_0004);
        put_desc(32'h040, 32'h000, 32'h600, 32'd20);
        start_addr = {32'h0E0, 32'h000};
        fetch_en = 1;
        repeat (100) @(negedge clk);
        check(req_n == 2, "R5 no fetch before drain", 32'(req_n), 2);
        check(px_valid[0] && px_data[31:0] == word_at(32'h400) && px_pal[0],
              "R3 head word tagged", px_data[31:0], word_at(32'h400));
        px_take = 2'b01;
        repeat (50) @(negedge clk);
        check(req_n >= 3 && req_addr_log[2] == 32'h040, "R5 fetch after drain",
              req_addr_log[2], 32'h040);
        fetch_en = 0;
        repeat (200) @(negedge clk);
    endtask

    // R2 R6 R7 R11: both channels, zero-length entry, self loops.
    task automatic t_dual();
        int bad0 = 0, bad1 = 0;
        do_reset();
        put_desc(32'h080, 32'h0C0, 32'h800, 32'h1000_0000);
        put_desc(32'h0C0, 32'h0C0, 32'h800, 32'd6);
        put_desc(32'h0E0, 32'h0E0, 32'hA00, 32'd8);
        start_addr = {32'h0E0, 32'h080};
        dual_en = 1; px_take = 2'b11; fetch_en = 1;
        wait_caps(24, 24, 4000);
        for (int k = 0; k < 24; k++) begin
            if (cap_d[0][k] !== word_at(32'h800 + 32'((k % 6) * 4)) || cap_p[0][k] !== 1'b0) bad0++;
            if (cap_d[1][k] !== word_at(32'hA00 + 32'((k % 8) * 4)) || cap_p[1][k] !== 1'b0) bad1++;
        end
        check(cap_n[0] >= 24 && bad0 == 0, "R2 zero length skipped, R6 self loop", 32'(bad0), 0);
        check(cap_n[1] >= 24 && bad1 == 0, "R7 R11 channel 1 own chain", 32'(bad1), 0);
        fetch_en = 0;
        repeat (200) @(negedge clk);
    endtask

    // R8: guarded starvation repeats words and sets the flag.
    task automatic t_underrun();
        int idx = 1, reps = 0, bad = 0;
        do_reset();
        put_desc(32'h0C0, 32'h0C0, 32'h800, 32'd2);
        start_addr = {32'h0E0, 32'h0C0};
        urun_protect = 1; px_take = 2'b01; fetch_en = 1;
        repeat (300) @(negedge clk);
        for (int k = 0; k < cap_n[0] && k < 512; k++) begin
            logic [31:0] e = word_at(32'h800 + 32'((idx % 2) * 4));
            if (k == 0) begin
                if (cap_d[0][0] !== word_at(32'h800)) bad++;
            end else if (cap_d[0][k] === cap_d[0][k-1]) reps++;
            else if (cap_d[0][k] === e) idx++;
            else bad++;
        end
        check(bad == 0, "R8 repeat equals last word", 32'(bad), 0);
        check(reps > 0, "R8 repeats occurred", 32'(reps), 1);
        check(urun_flag[0] == 1'b1, "R8 flag set", 32'(urun_flag[0]), 1);
        px_take = 2'b00; fetch_en = 0;
        repeat (40) @(negedge clk);
        check(urun_flag[0] == 1'b1, "R8 flag sticky", 32'(urun_flag[0]), 1);
        fetch_en = 1;
        repeat (3) @(negedge clk);
        check(urun_flag[0] == 1'b0, "R8 flag cleared on restart", 32'(urun_flag[0]), 0);
        fetch_en = 0;
        px_take = 2'b01;
        repeat (100) @(negedge clk);
    endtask

    // R10: stop at a burst boundary and restart from the start pointer.
    task automatic t_stop_restart();
        int n_after;
        do_reset();
        put_desc(32'h000, 32'h000, 32'h400, 32'd64);
        start_addr = {32'h0E0, 32'h000};
        px_take = 2'b01; fetch_en = 1;
        for (int i = 0; i < 2000 && req_n < 3; i++) @(negedge clk);
        fetch_en = 0;
        repeat (100) @(negedge clk);
        n_after = req_n;
        repeat (100) @(negedge clk);
        check(req_n == n_after, "R10 no request after stop", 32'(req_n), 32'(n_after));
        check(cap_n[0] == 16 * (n_after - 1), "R10 whole bursts only",
              32'(cap_n[0]), 32'(16 * (n_after - 1)));
        clear_logs();
        fetch_en = 1;
        repeat (20) @(negedge clk);
        check(req_n >= 1 && req_addr_log[0] == 32'h000 && req_len_log[0] == 4,
              "R10 restart at start pointer", req_addr_log[0], 32'h000);
        fetch_en = 0;
        repeat (200) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_pal_loop();
        t_drain_gate();
        t_dual();
        t_underrun();
        t_stop_restart();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule